// File: doc/BRIEF.md
# Dual-Mode Timer Input Capture

This block is one 16-bit counter with one input-capture register. The counter moves up or down by one on each system clock where the count-clock enable is high. When the selected edge of the trigger input is seen, the register takes a copy of the counter in a single clock, so a read never sees part of an old value and part of a new one. Each capture sets a flag. If DMA is enabled for the channel, each capture also raises a request so an external controller can fetch the captured halfword.

A mode input chooses how the trigger is observed. In synchronous mode the trigger goes through a two-flop synchroniser and is then compared only on count-clock ticks, so capture stays in step with the counter. A pulse that starts and ends between two ticks is lost. In asynchronous mode the trigger edge itself sets a holding latch, so a pulse of any width is caught. The latch is then carried into the system-clock domain and cleared once the capture is taken.

Top module: `dual_mode_capture`

## Requirements
- R1: While reset is low, and right after it, the counter and `cap_val` are 0, and `cap_flag` and `dma_req` are low.
- R2: On each clock edge with `cnt_en` high, the counter adds one if `cnt_up` is 1 and subtracts one if it is 0, wrapping modulo 2^16. It holds when `cnt_en` is low.
- R3: With `sync_mode` = 1, the trigger passes two system-clock flops. On a clock edge with `cnt_en` high, a selected edge between the level sampled at the previous tick and the current synchronised level captures the counter value that stands before that edge's update.
- R4: With `sync_mode` = 1, a trigger pulse that rises and falls between two count ticks causes no capture.
- R5: With `sync_mode` = 0, a selected trigger edge of any width is held by a latch. It causes a capture on the third rising clock edge after the trigger edge. The full 16-bit counter value standing before that clock's update is stored.
- R6: `edge_sel` encoding: 0 = no capture, 1 = rising edge, 2 = falling edge, 3 = both edges. An unselected edge leaves the flag and `cap_val` untouched.
- R7: A capture sets `cap_flag` on the capture edge. `flag_clr` clears it on the next edge. If a capture and `flag_clr` happen in the same cycle, the flag stays set.
- R8: With `dma_en` = 1, a capture raises `dma_req` on the capture edge, and it stays high until `dma_ack` is seen.
- R9: `dma_ack` clears both `dma_req` and `cap_flag` on the next edge. A capture in the same cycle keeps both set.
- R10: With `dma_en` = 0, a capture never raises `dma_req`.
- R11: `cap_val` changes only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable, one tick per high cycle |
| cnt_up | input | 1 | Count direction: 1 up, 0 down |
| cap_trig | input | 1 | Capture trigger input |
| sync_mode | input | 1 | 1 synchronous capture, 0 asynchronous capture |
| edge_sel | input | 2 | Trigger edge select |
| dma_en | input | 1 | DMA request enable for the channel |
| flag_clr | input | 1 | Clears the capture flag |
| dma_ack | input | 1 | DMA acknowledge, clears request and flag |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| dma_req | output | 1 | DMA request |

## Verification
A wrong counter step or a wrong direction shows up in the next captured value, which departs from a counter modelled from the enables the bench drives. A latch that is never set or never released shows up within three clocks of a trigger edge, as a missing flag or a missing second capture. A synchroniser one stage too short or too long moves the captured value by exactly one count. Errors in flag or request priority show up on the edge right after a same-cycle clear or acknowledge.

// File: rtl/dual_mode_capture.sv
module dual_mode_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_up,
  input  logic          cap_trig,
  input  logic          sync_mode,
  input  logic [1:0]    edge_sel,
  input  logic          dma_en,
  input  logic          flag_clr,
  input  logic          dma_ack,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          dma_req
);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_up ? count + CW'(1) : count - CW'(1);

  // synchronous path: two flops, then compared at count ticks
  logic trig_m, trig_q, t_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig_m <= 1'b0;
      trig_q <= 1'b0;
      t_last <= 1'b0;
    end else begin
      trig_m <= cap_trig;
      trig_q <= trig_m;
      if (cnt_en) t_last <= trig_q;
    end

  wire s_rise   = trig_q & ~t_last;
  wire s_fall   = ~trig_q & t_last;
  wire sync_hit = sync_mode & cnt_en & ((edge_sel[0] & s_rise) | (edge_sel[1] & s_fall));

  // asynchronous path: edge-set latches, resolved into clk domain
  logic lat_r, lat_f, clr_q, a_m, a_q, a_d;
  wire  lat_clr = ~rst_n | clr_q;

  always_ff @(posedge cap_trig or posedge lat_clr)
    if (lat_clr)                        lat_r <= 1'b0;
    else if (!sync_mode && edge_sel[0]) lat_r <= 1'b1;

  always_ff @(negedge cap_trig or posedge lat_clr)
    if (lat_clr)                        lat_f <= 1'b0;
    else if (!sync_mode && edge_sel[1]) lat_f <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_m   <= 1'b0;
      a_q   <= 1'b0;
      a_d   <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      a_m   <= lat_r | lat_f;
      a_q   <= a_m;
      a_d   <= a_q;
      clr_q <= a_q;
    end

  wire async_hit = a_q & ~a_d;
  wire cap_evt   = sync_hit | async_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (cap_evt) cap_val <= count;
      if (cap_evt)                    cap_flag <= 1'b1;
      else if (flag_clr || dma_ack)   cap_flag <= 1'b0;
      if (cap_evt && dma_en)          dma_req  <= 1'b1;
      else if (dma_ack)               dma_req  <= 1'b0;
    end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> count == ($past(cnt_up) ? $past(count) + CW'(1) : $past(count) - CW'(1)));

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !cap_flag);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);

  // R9
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && !cap_evt) |=> (!dma_req && !cap_flag));

  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(dma_en));

endmodule

// File: tb/tb_dual_mode_capture.sv
module tb_dual_mode_capture;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, cnt_up = 1'b1, cap_trig = 1'b0, sync_mode = 1'b0;
  logic [1:0] edge_sel = 2'd1;
  logic dma_en = 1'b0, flag_clr = 1'b0, dma_ack = 1'b0;
  logic [15:0] cap_val;
  logic cap_flag, dma_req;

  int n_tests = 0, n_fail = 0;
  logic [15:0] cm;
  logic [15:0] expq[$];
  logic pflag = 1'b0;
  logic [15:0] exp_v, held;

  always #(CLK_P/2) clk = ~clk;

  dual_mode_capture dut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .cap_trig(cap_trig), .sync_mode(sync_mode), .edge_sel(edge_sel), .dma_en(dma_en),
    .flag_clr(flag_clr), .dma_ack(dma_ack), .cap_val(cap_val), .cap_flag(cap_flag),
    .dma_req(dma_req));

  // counter model per R2
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cm <= 16'd0;
    else if (cnt_en) cm <= cnt_up ? cm + 16'd1 : cm - 16'd1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: every flag rise consumes one expected capture (R3 R5 R7)
  always @(negedge clk) begin
    if (rst_n && cap_flag && !pflag) begin
      if (expq.size() == 0) chk(1'b0, "R7 unexpected capture", {16'd0, cap_val}, 32'd0);
      else begin
        exp_v = expq.pop_front();
        chk(cap_val == exp_v, "R5/R3 captured value", {16'd0, cap_val}, {16'd0, exp_v});
      end
    end
    pflag = cap_flag;
  end

  task automatic pulse();
    #1 cap_trig = ~cap_trig;
    #2 cap_trig = ~cap_trig;
  endtask

  task automatic acap_push();
    @(posedge clk); @(posedge clk); @(negedge clk);
    expq.push_back(cm);
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic sync_cap(input logic [15:0] expv, input bit push);
    repeat (3) @(negedge clk);
    if (push) expq.push_back(expv);
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cap_val == 16'd0, "R1 cap_val", {16'd0, cap_val}, 32'd0);
    chk(cap_flag == 1'b0, "R1 cap_flag", {31'd0, cap_flag}, 32'd0);
    chk(dma_req == 1'b0, "R1 dma_req", {31'd0, dma_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap_val == 16'd0 && !cap_flag && !dma_req, "R1 after release", {16'd0, cap_val}, 32'd0);
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);

    // R5 R6: narrow rising pulse in asynchronous mode, counter running
    pulse(); acap_push(); clr_flag(); settle();

    // R6: rising edge with falling selected is ignored
    edge_sel = 2'd2;
    held = cap_val;
    #1 cap_trig = 1'b1;
    settle();
    chk(!cap_flag && cap_val == held, "R6 rise ignored when falling selected", {31'd0, cap_flag}, 32'd0);
    // R6: narrow low pulse, falling edge caught
    pulse(); acap_push(); clr_flag(); settle();

    // R6: both edges with a wide pulse give two captures
    edge_sel = 2'd3;
    #1 cap_trig = 1'b0;
    acap_push(); clr_flag(); settle();
    #1 cap_trig = 1'b1;
    acap_push(); clr_flag(); settle();

    // R6 R11: edge select 0
    edge_sel = 2'd0;
    held = cap_val;
    pulse(); settle();
    chk(!cap_flag, "R6 edge_sel 0 no flag", {31'd0, cap_flag}, 32'd0);
    chk(cap_val == held, "R11 cap_val held", {16'd0, cap_val}, {16'd0, held});
    #1 cap_trig = 1'b0;
    settle();

    // R8 R9: DMA request and acknowledge
    edge_sel = 2'd1; dma_en = 1'b1;
    pulse(); acap_push();
    @(negedge clk);
    chk(dma_req, "R8 request raised", {31'd0, dma_req}, 32'd1);
    repeat (3) @(negedge clk);
    chk(dma_req, "R8 request held", {31'd0, dma_req}, 32'd1);
    dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk(!dma_req && !cap_flag, "R9 ack clears", {30'd0, dma_req, cap_flag}, 32'd0);
    settle();

    // R7 R9: capture beats clear and ack in the same cycle
    pulse(); acap_push(); settle();
    pulse();
    @(posedge clk); @(posedge clk); @(negedge clk);
    exp_v = cm; dma_ack = 1'b1; flag_clr = 1'b1;
    @(negedge clk); dma_ack = 1'b0; flag_clr = 1'b0;
    chk(cap_flag, "R7 capture wins over clear", {31'd0, cap_flag}, 32'd1);
    chk(dma_req, "R9 capture wins over ack", {31'd0, dma_req}, 32'd1);
    chk(cap_val == exp_v, "R5 value on same-cycle clear", {16'd0, cap_val}, {16'd0, exp_v});
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk(!dma_req && !cap_flag, "R9 ack alone", {30'd0, dma_req, cap_flag}, 32'd0);
    settle();

    // R10
    dma_en = 1'b0;
    pulse(); acap_push();
    @(negedge clk);
    chk(!dma_req, "R10 no request without enable", {31'd0, dma_req}, 32'd0);
    // R7 flag_clr alone
    clr_flag();
    chk(!cap_flag, "R7 flag_clr clears", {31'd0, cap_flag}, 32'd0);
    settle();

    // R3: synchronous capture at a tick
    cnt_en = 1'b0; sync_mode = 1'b1;
    settle();
    #1 cap_trig = 1'b1;
    sync_cap(cm, 1'b1);
    clr_flag();
    // R6 falling edge not selected in synchronous mode
    #1 cap_trig = 1'b0;
    sync_cap(16'd0, 1'b0);
    chk(!cap_flag, "R6 sync falling ignored", {31'd0, cap_flag}, 32'd0);

    // R4: pulses between ticks are lost
    held = cap_val;
    #1 cap_trig = 1'b1;
    @(negedge clk); cap_trig = 1'b0;
    sync_cap(16'd0, 1'b0);
    pulse();
    sync_cap(16'd0, 1'b0);
    chk(!cap_flag && cap_val == held, "R4 narrow pulse lost in sync mode", {31'd0, cap_flag}, 32'd0);

    // R2: count down through zero, capture the wrapped value
    cnt_up = 1'b0; cnt_en = 1'b1;
    while (cm != 16'd3) @(negedge clk);
    repeat (5) @(negedge clk);
    cnt_en = 1'b0;
    #1 cap_trig = 1'b1;
    sync_cap(16'hFFFE, 1'b1);
    clr_flag(); settle();

    chk(expq.size() == 0, "R5 all expected captures seen", expq.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule